// File: doc/BRIEF.md
# Collatz Step Register with Ordered Rule Scheduling

This block holds one state word that two guarded update rules try to change in every clock cycle. The rules run in a fixed order inside the cycle. The first rule halves an even value. The second rule replaces an odd value with three times the value plus one. The word has two logical access ports. A read through the later port sees a write made through the earlier port in the same cycle, so one clock edge can commit the effects of both rules in sequence.

Each cycle has an access log. Every read and write is recorded there and checked against port-ordering legality rules. An access that breaks a rule cancels the rule that made it, and the cancelled rule leaves nothing in the log. The committed end-of-cycle value therefore always equals the result of running the surviving rules one after another in schedule order.

A host loads a start value, raises the enable and watches the value, the done flag and the per-rule fired and aborted flags. Those flags are registered once per cycle.

Top module: `czs_step_reg`

## Requirements
- R1: After reset the value is 0, done is low, and all four fired and aborted flags are low.
- R2: When load is high, the next value is load_value, whatever enable is, and both fired flags go low in that same cycle.
- R3: When load is low and enable is low, the value holds and both fired flags go low.
- R4: done is high exactly while the value equals 1. While done is high, neither rule runs and the value holds.
- R5: For an odd value with the rules active, the next value is (3*v+1) modulo 2^32. Only the triple flag fires.
- R6: For an even value v whose half is even, with the rules active, the next value is v/2. Only the halve flag fires.
- R7: For an even value whose half is odd, both rules commit in one cycle. The next value is 3*(v/2)+1 and both fired flags are high.
- R8: Under the fixed order (halve first through port 0, then triple through port 1), no access breaks a legality rule. Both aborted flags therefore stay low.
- R9: A value of 0 counts as even. It halves to 0 every active cycle, and the halve flag stays high.
- R10: The fired and aborted flags are registered. Each one describes the cycle whose clock edge produced the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Load strobe; takes priority over rule execution |
| load_value | input | 32 | Start value captured on load |
| enable | input | 1 | Allows the rules to run |
| value | output | 32 | Current register value |
| done | output | 1 | High while value equals 1 |
| fired_halve | output | 1 | Halve rule committed in the previous cycle |
| fired_triple | output | 1 | Triple rule committed in the previous cycle |
| aborted_halve | output | 1 | Halve rule was cancelled in the previous cycle |
| aborted_triple | output | 1 | Triple rule was cancelled in the previous cycle |

## Verification
A start of 27 walks a long trajectory. It mixes single-rule steps with cycles where the halve result is odd, so the triple rule reads the port-0 write. This separates correct port forwarding from a model that reads only the start-of-cycle value. A start of 6 with enable toggling tells idle cycles apart from active ones. A start of 0 exercises the degenerate even case. A start of all-ones exercises the modular wrap of 3v+1. Loads of 1 and 2 exercise the freeze on done and the both-fire case directly, and a load with enable high shows that load wins over the rules.

// File: rtl/czs_pkg.sv
package czs_pkg;

  // Access record for one register within one clock cycle.
  typedef struct packed {
    logic rd0;
    logic rd1;
    logic wr0;
    logic wr1;
  } czs_log_t;

  localparam czs_log_t LOG_EMPTY = '0;

  // Port-0 read: nothing may have been written yet this cycle.
  function automatic logic rd0_ok(czs_log_t l);
    return !(l.wr0 || l.wr1);
  endfunction

  // Port-1 read: no port-1 write may precede it.
  function automatic logic rd1_ok(czs_log_t l);
    return !l.wr1;
  endfunction

  // Port-0 write: no port-1 read and no write may precede it.
  function automatic logic wr0_ok(czs_log_t l);
    return !(l.rd1 || l.wr0 || l.wr1);
  endfunction

  // Port-1 write: at most one per cycle.
  function automatic logic wr1_ok(czs_log_t l);
    return !l.wr1;
  endfunction

endpackage

// File: rtl/czs_halve_rule.sv
module czs_halve_rule #(
  parameter int W = 32
) (
  input  logic             active,
  input  czs_pkg::czs_log_t log_in,
  input  logic [W-1:0]     cur,
  output czs_pkg::czs_log_t log_out,
  output logic             wr_en,
  output logic [W-1:0]     wr_val,
  output logic             fired,
  output logic             aborted
);
  import czs_pkg::*;

  czs_log_t after_rd;
  logic     guard;
  logic     legal;

  always_comb begin
    after_rd     = log_in;
    after_rd.rd0 = 1'b1;
    guard        = ~cur[0];
    legal        = rd0_ok(log_in) && (!guard || wr0_ok(after_rd));
    fired        = active && legal && guard;
    aborted      = active && !legal;
    wr_en        = fired;
    wr_val       = cur >> 1;
    log_out      = log_in;
    if (active && legal) begin
      log_out     = after_rd;
      log_out.wr0 = after_rd.wr0 | guard;
    end
  end

endmodule

// File: rtl/czs_triple_rule.sv
module czs_triple_rule #(
  parameter int W = 32
) (
  input  logic             active,
  input  czs_pkg::czs_log_t log_in,
  input  logic [W-1:0]     cur,
  input  logic             p0_wr_en,
  input  logic [W-1:0]     p0_wr_val,
  output czs_pkg::czs_log_t log_out,
  output logic             wr_en,
  output logic [W-1:0]     wr_val,
  output logic             fired,
  output logic             aborted
);
  import czs_pkg::*;

  czs_log_t     after_rd;
  logic [W-1:0] seen;
  logic         guard;
  logic         legal;

  always_comb begin
    // Port 1 forwards an earlier port-0 write from this cycle.
    seen         = p0_wr_en ? p0_wr_val : cur;
    after_rd     = log_in;
    after_rd.rd1 = 1'b1;
    guard        = seen[0];
    legal        = rd1_ok(log_in) && (!guard || wr1_ok(after_rd));
    fired        = active && legal && guard;
    aborted      = active && !legal;
    wr_en        = fired;
    wr_val       = (seen << 1) + seen + W'(1);
    log_out      = log_in;
    if (active && legal) begin
      log_out     = after_rd;
      log_out.wr1 = after_rd.wr1 | guard;
    end
  end

endmodule

// File: rtl/czs_step_reg.sv
module czs_step_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_value,
  input  logic         enable,
  output logic [W-1:0] value,
  output logic         done,
  output logic         fired_halve,
  output logic         fired_triple,
  output logic         aborted_halve,
  output logic         aborted_triple
);
  import czs_pkg::*;

  localparam int NRULES = 2;

  logic [1:0]   rst_sync_q;
  logic         rst_ok;
  logic [W-1:0] value_q, value_d;
  logic         value_en;
  logic         active;

  czs_log_t     log_h, log_t;
  logic         h_wr_en, t_wr_en;
  logic [W-1:0] h_wr_val, t_wr_val;
  logic [NRULES-1:0] fired_d, fired_q, abort_d, abort_q;

  // Reset synchronizer: assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  assign done   = (value_q == W'(1));
  assign active = enable && !load && !done;

  czs_halve_rule #(.W(W)) halve_i (
    .active  (active),
    .log_in  (LOG_EMPTY),
    .cur     (value_q),
    .log_out (log_h),
    .wr_en   (h_wr_en),
    .wr_val  (h_wr_val),
    .fired   (fired_d[0]),
    .aborted (abort_d[0])
  );

  czs_triple_rule #(.W(W)) triple_i (
    .active    (active),
    .log_in    (log_h),
    .cur       (value_q),
    .p0_wr_en  (h_wr_en),
    .p0_wr_val (h_wr_val),
    .log_out   (log_t),
    .wr_en     (t_wr_en),
    .wr_val    (t_wr_val),
    .fired     (fired_d[1]),
    .aborted   (abort_d[1])
  );

  // Next state: load, then port-1 write, then port-0 write, else hold.
  always_comb begin
    value_en = load || t_wr_en || h_wr_en;
    if (load)         value_d = load_value;
    else if (t_wr_en) value_d = t_wr_val;
    else if (h_wr_en) value_d = h_wr_val;
    else              value_d = value_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      value_q <= '0;
    end else if (value_en) begin
      value_q <= value_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      fired_q <= '0;
      abort_q <= '0;
    end else begin
      fired_q <= fired_d;
      abort_q <= abort_d;
    end
  end

  assign value          = value_q;
  assign fired_halve    = fired_q[0];
  assign fired_triple   = fired_q[1];
  assign aborted_halve  = abort_q[0];
  assign aborted_triple = abort_q[1];

  // Final log is not observed further; kept for completeness of the chain.
  logic unused_log;
  assign unused_log = ^log_t;

endmodule

// File: rtl/czs_step_checker.sv
module czs_step_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         load,
  input logic [W-1:0] load_value,
  input logic         enable,
  input logic [W-1:0] value,
  input logic         done,
  input logic         fired_halve,
  input logic         fired_triple,
  input logic         aborted_halve,
  input logic         aborted_triple
);

  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_ok)
    load |=> (value == $past(load_value)) && !fired_halve && !fired_triple);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load && !enable) |=> $stable(value) && !fired_halve && !fired_triple);

  a_r4_done_freeze: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load && done) |=> $stable(value) && done);

  a_r5_odd_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load && enable && !done && value[0]) |=>
      fired_triple && !fired_halve &&
      (value == (($past(value) << 1) + $past(value) + W'(1))));

  a_r6_even_halve: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load && enable && !done && !value[0]) |=> fired_halve);

  a_r8_no_abort: assert property (@(posedge clk) disable iff (!rst_ok)
    !aborted_halve && !aborted_triple);

endmodule

bind czs_step_reg czs_step_checker #(.W(W)) chk_i (
  .clk            (clk),
  .rst_ok         (rst_ok),
  .load           (load),
  .load_value     (load_value),
  .enable         (enable),
  .value          (value),
  .done           (done),
  .fired_halve    (fired_halve),
  .fired_triple   (fired_triple),
  .aborted_halve  (aborted_halve),
  .aborted_triple (aborted_triple)
);

// File: tb/czs_step_reg_tb_top.sv
`timescale 1ns/1ps
module czs_step_reg_tb_top;

  logic        clk;
  logic        rst_n;
  logic        load;
  logic [31:0] load_value;
  logic        enable;
  logic [31:0] value;
  logic        done;
  logic        fired_halve, fired_triple, aborted_halve, aborted_triple;

  int vectors;
  int miscompares;

  // Reference state
  longint m_val;
  bit     m_fh, m_ft;

  czs_step_reg #(.W(32)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (load),
    .load_value     (load_value),
    .enable         (enable),
    .value          (value),
    .done           (done),
    .fired_halve    (fired_halve),
    .fired_triple   (fired_triple),
    .aborted_halve  (aborted_halve),
    .aborted_triple (aborted_triple)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, update the model, compare next falling edge.
  task automatic step(input bit l, input longint lv, input bit en);
    string tag;
    longint w;
    load       = l;
    load_value = lv[31:0];
    enable     = en;
    if (l) begin
      m_val = lv & 64'hFFFF_FFFF; m_fh = 0; m_ft = 0; tag = "R2";
    end else if (!en) begin
      m_fh = 0; m_ft = 0; tag = "R3";
    end else if (m_val == 1) begin
      m_fh = 0; m_ft = 0; tag = "R4";
    end else begin
      w = m_val; m_fh = 0; m_ft = 0;
      if (w % 2 == 0) begin w = w / 2; m_fh = 1; end
      if (w % 2 == 1) begin w = (3 * w + 1) & 64'hFFFF_FFFF; m_ft = 1; end
      m_val = w;
      if (m_fh && m_ft)  tag = "R7";
      else if (m_fh)     tag = (m_val == 0) ? "R9" : "R6";
      else               tag = "R5";
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "value", value, m_val);
    chk("R4", "done", done, (m_val == 1) ? 1 : 0);
    chk({tag, "/R10"}, "fired_halve", fired_halve, m_fh);
    chk({tag, "/R10"}, "fired_triple", fired_triple, m_ft);
    chk("R8", "aborted_halve", aborted_halve, 0);
    chk("R8", "aborted_triple", aborted_triple, 0);
  endtask

  initial begin
    vectors = 0; miscompares = 0;
    rst_n = 1'b0; load = 1'b0; load_value = '0; enable = 1'b0;
    m_val = 0; m_fh = 0; m_ft = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "value", value, 0);
    chk("R1", "done", done, 0);
    chk("R1", "fired_halve", fired_halve, 0);
    chk("R1", "fired_triple", fired_triple, 0);
    chk("R1", "aborted_halve", aborted_halve, 0);
    chk("R1", "aborted_triple", aborted_triple, 0);

    // R9: zero keeps halving to zero
    for (int i = 0; i < 3; i++) step(0, 0, 1);

    // Long trajectory, mixing R5, R6, R7
    step(1, 27, 1);
    for (int i = 0; i < 130; i++) step(0, 0, 1);

    // R3: enable toggling
    step(1, 6, 1);
    for (int i = 0; i < 10; i++) step(0, 0, (i % 3) != 0);

    // R4: done freezes
    step(1, 1, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 1);

    // R5: wrap of 3v+1
    step(1, 64'hFFFF_FFFF, 1);
    for (int i = 0; i < 2; i++) step(0, 0, 1);

    // R2: load with enable low, then load overriding enabled rules
    step(1, 7, 0);
    step(1, 9, 1);

    // R7: 2 halves to 1 then triples to 4 in one cycle
    step(1, 2, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule